// File: doc/BRIEF.md
# Line-Synchronous Task Sequencer

The block runs two 8-bit control ports from a list of timed tasks. Each task holds a video line number and the two port bytes for that line. A horizontal sync input advances a line counter. A vertical sync input restarts the counter and rewinds the list. On every line the block compares the counter with the current task. When they match, it stages the task's bytes in a holding register. The staged bytes reach the ports on the next horizontal sync, one line after the match.

The task memory has two banks. The block plays the active bank while a new list is written into the other bank. Writing a new list takes three steps: a start strobe captures the list's initial port values and clears the inactive bank, record writes fill that bank in line order, and an end strobe marks the bank ready. The banks swap at the next frame start, which is a vertical sync seen while the field input is high. At the swap the ports take the new list's initial values.

Top module: `line_task_seq`

## Requirements
- R1: After reset, port_a_o, port_b_o and line_o are all zero, bank 0 is active and no swap is pending.
- R2: Each falling edge of hsync_ni, after a two-flop synchronizer, adds exactly one to line_o.
- R3: A falling edge of vsync_ni sets line_o to 1, rewinds the read pointer to record 0 of the active bank, and discards any staged data that has not yet been driven out.
- R4: When a horizontal sync finds line_o equal to the line number of the current record, the record's bytes appear on port_a_o and port_b_o at the next horizontal sync, not at the matching one.
- R5: Records are used in the order they were written, and each match moves the read pointer on by one record. Line numbers must be written in ascending order.
- R6: Once every written record of the active bank has matched, no further match occurs before the next vertical sync, and the ports hold their last values.
- R7: list_start_i, rec_wr_i and list_end_i act only on the inactive bank. They do not change the ports or the active list.
- R8: On a vertical sync edge with field1_i high and a completed list pending, the banks swap, the pending flag clears, and the ports take the init_a_i and init_b_i values captured at list_start_i.
- R9: A vertical sync edge with field1_i low restarts the line count but does not swap banks, even when a list is pending.
- R10: Record writes past DEPTH records in one list are dropped and never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_ni | input | 1 | Horizontal sync, active low, asynchronous |
| vsync_ni | input | 1 | Vertical sync, active low, asynchronous |
| field1_i | input | 1 | High during the first field; allows a bank swap |
| list_start_i | input | 1 | Start a new list in the inactive bank and capture its initial port values |
| init_a_i | input | 8 | Initial value for port A, captured at list start |
| init_b_i | input | 8 | Initial value for port B, captured at list start |
| rec_wr_i | input | 1 | Append one record to the inactive bank |
| rec_line_i | input | LINE_W | Line number of the record being written |
| rec_a_i | input | 8 | Port A byte of the record |
| rec_b_i | input | 8 | Port B byte of the record |
| list_end_i | input | 1 | Mark the inactive list complete so it swaps at the next frame start |
| port_a_o | output | 8 | Control port A |
| port_b_o | output | 8 | Control port B |
| line_o | output | LINE_W | Current line count |

## Verification
The bench builds the block with DEPTH = 4, LINE_W = 10 and SYNC_STAGES = 2. The small depth lets a five-record list overflow a bank, so the dropped fifth record and the end-of-list hold (R6, R10) can be tested within a few lines. The bench plays two lists back to back and checks one-line-late output, the swap gated by field1_i, and a vertical sync that arrives while a matched record is still staged.

// File: rtl/lts_pkg.sv
package lts_pkg;
  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
  } port_pair_t;
endpackage

// File: rtl/lts_sync_fall.sv
module lts_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic fall_o
);
  // sh[STAGES-1] is the last sync stage, sh[STAGES] its delayed copy
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], async_ni};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/lts_task_store.sv
module lts_task_store
  import lts_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH + 1),
  localparam int A_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_bank_i,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  port_pair_t        wr_data_i,
  input  logic              rd_bank_i,
  input  logic [A_W-1:0]    rd_idx_i,
  output logic [LINE_W-1:0] rd_line_o,
  output port_pair_t        rd_data_o,
  output logic [IDX_W-1:0]  rd_cnt_o
);
  logic [LINE_W-1:0] bank_line [2];
  port_pair_t        bank_data [2];
  logic [IDX_W-1:0]  bank_cnt  [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [LINE_W-1:0] line_mem [DEPTH];
    port_pair_t        data_mem [DEPTH];
    logic [IDX_W-1:0]  cnt_q;
    logic              sel, room;

    assign sel  = (wr_bank_i == 1'(b));
    assign room = (cnt_q < IDX_W'(DEPTH));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         cnt_q <= '0;
      else if (sel && clr_i)               cnt_q <= '0;
      else if (sel && wr_en_i && room)     cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel && wr_en_i && !clr_i && room) begin
        line_mem[cnt_q[A_W-1:0]] <= wr_line_i;
        data_mem[cnt_q[A_W-1:0]] <= wr_data_i;
      end
    end

    assign bank_line[b] = line_mem[rd_idx_i];
    assign bank_data[b] = data_mem[rd_idx_i];
    assign bank_cnt[b]  = cnt_q;

    a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= IDX_W'(DEPTH));
  end

  assign rd_line_o = bank_line[rd_bank_i];
  assign rd_data_o = bank_data[rd_bank_i];
  assign rd_cnt_o  = bank_cnt[rd_bank_i];
endmodule

// File: rtl/line_task_seq.sv
module line_task_seq
  import lts_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(DEPTH + 1),
  localparam int A_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_ni,
  input  logic              vsync_ni,
  input  logic              field1_i,
  input  logic              list_start_i,
  input  logic [7:0]        init_a_i,
  input  logic [7:0]        init_b_i,
  input  logic              rec_wr_i,
  input  logic [LINE_W-1:0] rec_line_i,
  input  logic [7:0]        rec_a_i,
  input  logic [7:0]        rec_b_i,
  input  logic              list_end_i,
  output logic [7:0]        port_a_o,
  output logic [7:0]        port_b_o,
  output logic [LINE_W-1:0] line_o
);
  logic              hs_fall, vs_fall, frame_start, match;
  logic              act_q, pend_q, held_v_q, shadow;
  logic [IDX_W-1:0]  ptr_q, rd_cnt;
  logic [LINE_W-1:0] line_q, rd_line;
  port_pair_t        held_q, port_q, rd_data;
  port_pair_t        init_q [2];

  lts_sync_fall #(.STAGES(SYNC_STAGES)) u_hs (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_ni(hsync_ni), .fall_o(hs_fall));
  lts_sync_fall #(.STAGES(SYNC_STAGES)) u_vs (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_ni(vsync_ni), .fall_o(vs_fall));

  assign shadow = ~act_q;

  lts_task_store #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_bank_i(shadow),
    .clr_i    (list_start_i),
    .wr_en_i  (rec_wr_i),
    .wr_line_i(rec_line_i),
    .wr_data_i({rec_a_i, rec_b_i}),
    .rd_bank_i(act_q),
    .rd_idx_i (ptr_q[A_W-1:0]),
    .rd_line_o(rd_line),
    .rd_data_o(rd_data),
    .rd_cnt_o (rd_cnt)
  );

  assign frame_start = vs_fall & field1_i;
  assign match       = hs_fall && (ptr_q < rd_cnt) && (rd_line == line_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      pend_q   <= 1'b0;
      ptr_q    <= '0;
      line_q   <= '0;
      held_v_q <= 1'b0;
      held_q   <= '0;
      port_q   <= '0;
      init_q[0] <= '0;
      init_q[1] <= '0;
    end else begin
      if (list_start_i) begin
        init_q[shadow] <= {init_a_i, init_b_i};
        pend_q         <= 1'b0;
      end else if (list_end_i) begin
        pend_q <= 1'b1;
      end
      if (vs_fall) begin
        line_q   <= LINE_W'(1);
        ptr_q    <= '0;
        held_v_q <= 1'b0;
        if (frame_start && pend_q) begin
          act_q  <= ~act_q;
          pend_q <= 1'b0;
          port_q <= init_q[shadow];
        end
      end else if (hs_fall) begin
        line_q   <= line_q + 1'b1;
        if (held_v_q) port_q <= held_q;
        held_v_q <= match;
        if (match) begin
          held_q <= rd_data;
          ptr_q  <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign port_a_o = port_q.a;
  assign port_b_o = port_q.b;
  assign line_o   = line_q;

  a_r2_line_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_fall && !vs_fall |=> line_o == LINE_W'($past(line_o) + 1'b1));
  a_r3_line_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_fall |=> line_o == LINE_W'(1) && !held_v_q);
  a_r4_port_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_fall && !vs_fall |=> $stable(port_a_o) && $stable(port_b_o));
  a_r6_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= rd_cnt);
  a_r8_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_fall && field1_i && pend_q |=> !pend_q && act_q != $past(act_q));
  a_r9_no_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_fall && !field1_i |=> $stable(act_q));
endmodule

// File: tb/line_task_seq_tb_top.sv
module line_task_seq_tb_top;
  localparam int LINE_W = 10;
  localparam int DEPTH  = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic hsync_ni = 1'b1, vsync_ni = 1'b1, field1_i = 1'b0;
  logic list_start_i = 1'b0, rec_wr_i = 1'b0, list_end_i = 1'b0;
  logic [7:0] init_a_i = '0, init_b_i = '0, rec_a_i = '0, rec_b_i = '0;
  logic [LINE_W-1:0] rec_line_i = '0;
  logic [7:0] port_a_o, port_b_o;
  logic [LINE_W-1:0] line_o;

  always #10 clk_i = ~clk_i;

  line_task_seq #(.LINE_W(LINE_W), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_ni(hsync_ni), .vsync_ni(vsync_ni),
    .field1_i(field1_i), .list_start_i(list_start_i), .init_a_i(init_a_i),
    .init_b_i(init_b_i), .rec_wr_i(rec_wr_i), .rec_line_i(rec_line_i),
    .rec_a_i(rec_a_i), .rec_b_i(rec_b_i), .list_end_i(list_end_i),
    .port_a_o(port_a_o), .port_b_o(port_b_o), .line_o(line_o));

  typedef struct {
    logic [7:0]        a;
    logic [7:0]        b;
    logic [LINE_W-1:0] line;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  event smp_ev;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;

  // monitor: pops expectations when the driver marks a sample point
  initial forever begin
    @(smp_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      if (port_a_o !== e.a || port_b_o !== e.b || line_o !== e.line) begin
        n_fail++;
        $display("FAIL %s: got a=%h b=%h line=%0d, expected a=%h b=%h line=%0d",
                 e.tag, port_a_o, port_b_o, line_o, e.a, e.b, e.line);
      end
    end
  end

  task automatic expect_now(input logic [7:0] a, input logic [7:0] b,
                            input int line, input string tag);
    exp_t e;
    e.a = a; e.b = b; e.line = LINE_W'(line); e.tag = tag;
    exp_q.push_back(e);
    ->smp_ev;
    @(negedge clk_i);
  endtask

  task automatic hs(input logic [7:0] a, input logic [7:0] b,
                    input int line, input string tag);
    hsync_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    hsync_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    expect_now(a, b, line, tag);
  endtask

  task automatic vs(input logic fld, input logic [7:0] a, input logic [7:0] b,
                    input string tag);
    field1_i = fld;
    vsync_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    vsync_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    field1_i = 1'b0;
    expect_now(a, b, 1, tag);
  endtask

  task automatic lst_start(input logic [7:0] a, input logic [7:0] b);
    init_a_i = a; init_b_i = b; list_start_i = 1'b1;
    @(negedge clk_i);
    list_start_i = 1'b0;
  endtask

  task automatic rec(input int line, input logic [7:0] a, input logic [7:0] b);
    rec_line_i = LINE_W'(line); rec_a_i = a; rec_b_i = b; rec_wr_i = 1'b1;
    @(negedge clk_i);
    rec_wr_i = 1'b0;
  endtask

  task automatic lst_end();
    list_end_i = 1'b1;
    @(negedge clk_i);
    list_end_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect_now(8'h00, 8'h00, 0, "R1 reset");

    lst_start(8'hA5, 8'h5A);
    rec(3, 8'h11, 8'h22);
    rec(5, 8'h33, 8'h44);
    rec(6, 8'h55, 8'h66);
    lst_end();
    expect_now(8'h00, 8'h00, 0, "R7 load leaves ports");

    vs(1'b0, 8'h00, 8'h00, "R9 no swap with field low");
    vs(1'b1, 8'hA5, 8'h5A, "R8 swap applies init");

    hs(8'hA5, 8'h5A, 2, "R2 line 1");
    hs(8'hA5, 8'h5A, 3, "R2 line 2");
    hs(8'hA5, 8'h5A, 4, "R4 not on matching sync");
    hs(8'h11, 8'h22, 5, "R4 one line later");
    hs(8'h11, 8'h22, 6, "R5 second record staged");
    hs(8'h33, 8'h44, 7, "R5 second record out");
    hs(8'h55, 8'h66, 8, "R5 back-to-back record");
    hs(8'h55, 8'h66, 9, "R6 list exhausted");

    lst_start(8'h01, 8'h02);
    rec(2, 8'h10, 8'h20);
    rec(3, 8'h30, 8'h40);
    rec(4, 8'h50, 8'h60);
    rec(5, 8'h70, 8'h80);
    rec(6, 8'hEE, 8'hEE);
    lst_end();
    hs(8'h55, 8'h66, 10, "R7 active list untouched");

    vs(1'b1, 8'h01, 8'h02, "R8 second swap");
    hs(8'h01, 8'h02, 2, "R5 line 1");
    hs(8'h01, 8'h02, 3, "R5 match line 2");
    hs(8'h10, 8'h20, 4, "R5 rec0 out");
    hs(8'h30, 8'h40, 5, "R5 rec1 out");
    hs(8'h50, 8'h60, 6, "R5 rec2 out");
    hs(8'h70, 8'h80, 7, "R10 rec3 out, fifth dropped");
    hs(8'h70, 8'h80, 8, "R10 no overflow match");

    vs(1'b0, 8'h70, 8'h80, "R3 restart without swap");
    hs(8'h70, 8'h80, 2, "R3 line 1");
    hs(8'h70, 8'h80, 3, "R3 rec0 staged again");
    vs(1'b0, 8'h70, 8'h80, "R3 staged data dropped");
    hs(8'h70, 8'h80, 2, "R3 nothing driven");
    hs(8'h70, 8'h80, 3, "R3 rec0 staged");
    hs(8'h10, 8'h20, 4, "R3 rewound to record 0");

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule